// File: doc/BRIEF.md
# Address-Monitor Wait Controller

This block lets one hardware thread sleep cheaply instead of spinning. Software first arms a watched address window, given as a base and a byte count. It then issues a wait command that carries a 64-bit timestamp deadline in two 32-bit halves. The thread is stalled until a snooped write lands inside the window or the external timestamp counter moves past the deadline, whichever comes first. A timeout-only variant of the wait ignores the window entirely.

A privileged cap register bounds every wait. The deadline actually used is the earlier of the caller's deadline and the issue time plus the cap. Each wait also selects a sleep depth. The light state leaves quickly, and the deep state takes longer to leave. A privileged enable bit can forbid the deep state. After the wake condition is seen, the stall stays up for the exit latency of the chosen state. A two-bit code then tells software why the wait ended.

Top module: `addr_monitor_wait`

## Requirements
- R1: After reset, `stall` is 0, `pwr_state` is 2'b00 and `wake_reason` is 2'b00. The cap register holds 100000 and the deep state is allowed.
- R2: When a wait is accepted at edge e0, the block stalls and leaves sleep at the first edge j > e0 where the sampled `tsc` is strictly greater than the effective deadline. Sleep lasts at least one cycle, even when the deadline has already passed.
- R3: The effective deadline is the smaller of {`wait_dl_hi`,`wait_dl_lo`} and the `tsc` value at issue plus the cap. When the cap is strictly smaller, the wake reason is 2'b11. Otherwise it is 2'b10, so a tie counts as the requested deadline. `cap_we` loads `cap_wdata` into the cap register.
- R4: During a monitored wait on an armed window, a snooped write with base <= address < base+size wakes the thread with reason 2'b01. This takes priority over a deadline reached in the same cycle. Writes outside the window have no effect, and a size of 0 matches nothing.
- R5: An in-window write seen while idle and armed sets a pending trigger. The next monitored wait then raises no stall, shows reason 2'b01 from the following cycle, and consumes the trigger.
- R6: An arm command clears any pending trigger.
- R7: A monitored wait issued before any arm behaves as a timeout-only wait. A timeout-only wait ignores snooped writes and leaves the pending trigger untouched.
- R8: While stalled, `pwr_state` is 2'b10 (deep) when `wait_deep_hint` was 1 and the enable bit was set at issue. Otherwise it is 2'b01 (light). It is 2'b00 whenever `stall` is low. `deep_en_we` loads `deep_en_wdata` into the enable bit.
- R9: After the wake edge, `stall` stays high for exactly LIGHT_LAT (2) cycles after a light sleep or DEEP_LAT (16) cycles after a deep sleep.
- R10: Wake reason codes are 00 none, 01 watched write, 10 requested deadline and 11 cap. An accepted wait clears the code to 00, and the code is held after the wake until the next wait.
- R11: A wait command presented while `stall` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tsc | input | 64 | Free-running timestamp counter |
| arm_valid | input | 1 | Arm the watched window |
| arm_base | input | ADDR_W | Window base address |
| arm_size | input | ADDR_W | Window size in bytes |
| wait_valid | input | 1 | Wait command |
| wait_monitored | input | 1 | 1: wait on the window and the deadline, 0: deadline only |
| wait_deep_hint | input | 1 | Request the deep sleep state |
| wait_dl_lo | input | 32 | Deadline, low half |
| wait_dl_hi | input | 32 | Deadline, high half |
| snoop_valid | input | 1 | Observed write strobe |
| snoop_addr | input | ADDR_W | Observed write address |
| cap_we | input | 1 | Write strobe for the cap register |
| cap_wdata | input | CAP_W | New cap in timestamp cycles |
| deep_en_we | input | 1 | Write strobe for the deep-state enable |
| deep_en_wdata | input | 1 | New deep-state enable value |
| stall | output | 1 | Thread stalled |
| pwr_state | output | 2 | 00 active, 01 light, 10 deep |
| wake_reason | output | 2 | Reason code of the last wait |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit cap, and exit latencies of 2 and 16. The reset cap of 100000 therefore governs one real, full-length wait. The short latencies and a reprogrammed cap of 3 or 40 let a sweep cover deadlines from two cycles in the past to eight in the future, both hint values and both enable values. That sweep covers every ordering of the requested deadline against the cap, including the tie. Each window test probes the addresses just below, at, and at the top of the window, and just past its end.

// File: rtl/addr_monitor_wait.sv
module addr_monitor_wait #(
  parameter int ADDR_W    = 32,
  parameter int CAP_W     = 32,
  parameter int CAP_RESET = 100000,
  parameter int LIGHT_LAT = 2,
  parameter int DEEP_LAT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       tsc,
  input  logic              arm_valid,
  input  logic [ADDR_W-1:0] arm_base,
  input  logic [ADDR_W-1:0] arm_size,
  input  logic              wait_valid,
  input  logic              wait_monitored,
  input  logic              wait_deep_hint,
  input  logic [31:0]       wait_dl_lo,
  input  logic [31:0]       wait_dl_hi,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              cap_we,
  input  logic [CAP_W-1:0]  cap_wdata,
  input  logic              deep_en_we,
  input  logic              deep_en_wdata,
  output logic              stall,
  output logic [1:0]        pwr_state,
  output logic [1:0]        wake_reason
);
  localparam int LAT_W = $clog2(DEEP_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SLEEP, S_EXIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] mon_base, mon_size;
  logic              armed, trig;
  logic [CAP_W-1:0]  cap;
  logic              deep_en;
  logic [63:0]       deadline;
  logic              dl_is_cap, use_mon, sleep_deep;
  logic [LAT_W-1:0]  lat_cnt;
  logic [1:0]        reason;

  wire in_range = snoop_valid && armed && (snoop_addr >= mon_base)
                  && ((snoop_addr - mon_base) < mon_size);
  wire [63:0] req_dl   = {wait_dl_hi, wait_dl_lo};
  wire [63:0] cap_dl   = tsc + {{(64-CAP_W){1'b0}}, cap};
  wire        cap_wins = cap_dl < req_dl;
  wire        issue    = wait_valid && (st == S_IDLE);
  wire        instant  = issue && wait_monitored && armed && trig;
  wire        hit_wake = (st == S_SLEEP) && use_mon && in_range;
  wire        tm_wake  = (st == S_SLEEP) && (tsc > deadline);
  wire [LAT_W-1:0] exit_lat = sleep_deep ? LAT_W'(DEEP_LAT - 1) : LAT_W'(LIGHT_LAT - 1);

  assign stall       = (st != S_IDLE);
  assign pwr_state   = !stall ? 2'b00 : (sleep_deep ? 2'b10 : 2'b01);
  assign wake_reason = reason;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_base <= '0;
      mon_size <= '0;
      armed    <= 1'b0;
      trig     <= 1'b0;
      cap      <= CAP_W'(CAP_RESET);
      deep_en  <= 1'b1;
    end else begin
      if (cap_we)     cap     <= cap_wdata;
      if (deep_en_we) deep_en <= deep_en_wdata;
      if (arm_valid) begin
        mon_base <= arm_base;
        mon_size <= arm_size;
        armed    <= 1'b1;
        trig     <= 1'b0;
      end else if (instant) begin
        trig <= 1'b0;
      end else if (st == S_IDLE && in_range) begin
        trig <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      deadline   <= '0;
      dl_is_cap  <= 1'b0;
      use_mon    <= 1'b0;
      sleep_deep <= 1'b0;
      lat_cnt    <= '0;
      reason     <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (issue) begin
          if (instant) begin
            reason <= 2'b01;
          end else begin
            reason     <= 2'b00;
            st         <= S_SLEEP;
            deadline   <= cap_wins ? cap_dl : req_dl;
            dl_is_cap  <= cap_wins;
            use_mon    <= wait_monitored && armed;
            sleep_deep <= wait_deep_hint && deep_en;
          end
        end
        S_SLEEP: if (hit_wake || tm_wake) begin
          reason  <= hit_wake ? 2'b01 : (dl_is_cap ? 2'b11 : 2'b10);
          st      <= S_EXIT;
          lat_cnt <= exit_lat;
        end
        S_EXIT: begin
          if (lat_cnt == '0) st <= S_IDLE;
          else               lat_cnt <= lat_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module addr_monitor_wait_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] pwr_state,
  input logic [1:0] wake_reason,
  input logic       wait_valid,
  input logic       wait_monitored,
  input logic       armed,
  input logic       trig,
  input logic       deep_en
);
  // R10
  reason_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> wake_reason == 2'b00);
  // R10
  reason_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> wake_reason != 2'b00);
  // R9
  exit_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(stall, 2));
  // R5
  instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_valid && !stall && wait_monitored && armed && trig) |=> (!stall && wake_reason == 2'b01));
  // R8
  deep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall) && pwr_state == 2'b10) |-> $past(deep_en));
endmodule

bind addr_monitor_wait addr_monitor_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .pwr_state(pwr_state),
  .wake_reason(wake_reason), .wait_valid(wait_valid),
  .wait_monitored(wait_monitored), .armed(armed), .trig(trig),
  .deep_en(deep_en)
);

// File: tb/tb_addr_monitor_wait.sv
module tb_addr_monitor_wait;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tsc = '0;
  logic        arm_valid = 0, wait_valid = 0, wait_monitored = 0, wait_deep_hint = 0;
  logic [31:0] arm_base = '0, arm_size = '0, wait_dl_lo = '0, wait_dl_hi = '0;
  logic        snoop_valid = 0, cap_we = 0, deep_en_we = 0, deep_en_wdata = 0;
  logic [31:0] snoop_addr = '0, cap_wdata = '0;
  logic        stall;
  logic [1:0]  pwr_state, wake_reason;
  int checks = 0, failures = 0;

  addr_monitor_wait dut (
    .clk(clk), .rst_n(rst_n), .tsc(tsc), .arm_valid(arm_valid), .arm_base(arm_base),
    .arm_size(arm_size), .wait_valid(wait_valid), .wait_monitored(wait_monitored),
    .wait_deep_hint(wait_deep_hint), .wait_dl_lo(wait_dl_lo), .wait_dl_hi(wait_dl_hi),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .cap_we(cap_we),
    .cap_wdata(cap_wdata), .deep_en_we(deep_en_we), .deep_en_wdata(deep_en_wdata),
    .stall(stall), .pwr_state(pwr_state), .wake_reason(wake_reason)
  );

  always #10 clk = ~clk;
  always @(posedge clk) tsc <= tsc + 64'd1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cap(input int v);
    cap_we = 1; cap_wdata = v; @(negedge clk); cap_we = 0;
  endtask

  task automatic set_den(input bit v);
    deep_en_we = 1; deep_en_wdata = v; @(negedge clk); deep_en_we = 0;
  endtask

  task automatic arm(input logic [31:0] b, input logic [31:0] s);
    arm_valid = 1; arm_base = b; arm_size = s; @(negedge clk); arm_valid = 0;
  endtask

  task automatic idle_write(input logic [31:0] a);
    snoop_valid = 1; snoop_addr = a; @(negedge clk); snoop_valid = 0;
  endtask

  task automatic run_wait(input bit mon, input bit hint, input longint off,
                          input int snoop_at, input logic [31:0] saddr, input int reissue_at,
                          output int cyc, output logic [1:0] pw, output logic [1:0] rs);
    longint t0;
    t0 = longint'(tsc);
    {wait_dl_hi, wait_dl_lo} = 64'(t0 + off);
    wait_valid = 1; wait_monitored = mon; wait_deep_hint = hint;
    @(negedge clk);
    wait_valid = 0;
    cyc = 0; pw = pwr_state;
    while (stall && cyc < 150000) begin
      cyc++;
      snoop_valid = (cyc == snoop_at); snoop_addr = saddr;
      wait_valid = (cyc == reissue_at);
      {wait_dl_hi, wait_dl_lo} = 64'(t0);
      @(negedge clk);
    end
    snoop_valid = 0; wait_valid = 0;
    rs = wake_reason;
  endtask

  function automatic int exp_cyc(longint off, longint cap, int lat);
    longint m;
    m = (off < cap) ? off : cap;
    return int'(((m + 1) < 1) ? 1 : (m + 1)) + lat;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R2 watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c; logic [1:0] pw, rs;
    logic [31:0] probe [4];
    bit hitexp [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 stall", stall, 0);
    check("R1 pwr_state", pwr_state, 0);
    check("R1 wake_reason", wake_reason, 0);

    // R1 R3 R8 R9: reset cap 100000 beats a deadline one further, deep allowed by default
    run_wait(0, 1, 100001, -1, 0, -1, c, pw, rs);
    check("R3 reset cap cycles", c, 100001 + 16);
    check("R8 default deep", pw, 2);
    check("R3 reset cap reason", rs, 3);
    check("R8 idle pwr", pwr_state, 0);

    // R7: unarmed monitored wait acts as timeout-only
    idle_write(32'h1000);
    run_wait(1, 0, 3, 2, 32'h1000, -1, c, pw, rs);
    check("R7 unarmed cycles", c, 4 + 2);
    check("R7 unarmed reason", rs, 2);

    // R2 R3 R8 R9 sweep
    foreach (hitexp[i]) hitexp[i] = 0;
    for (int den = 0; den < 2; den++) begin
      set_den(den[0]);
      for (int ci = 0; ci < 2; ci++) begin
        int capv;
        capv = ci ? 40 : 3;
        set_cap(capv);
        for (int hint = 0; hint < 2; hint++) begin
          for (int off = -2; off <= 8; off++) begin
            bit deep;
            deep = hint[0] && den[0];
            run_wait(0, hint[0], off, -1, 0, -1, c, pw, rs);
            check("R2 R9 sweep cycles", c, exp_cyc(off, capv, deep ? 16 : 2));
            check("R8 sweep pwr", pw, deep ? 2 : 1);
            check("R3 R10 sweep reason", rs, (capv < off) ? 3 : 2);
          end
        end
      end
    end
    set_den(1);
    set_cap(40);

    // R4 R5 window boundaries via the pending trigger
    probe[0] = 32'h0FFF; probe[1] = 32'h1000; probe[2] = 32'h103F; probe[3] = 32'h1040;
    hitexp[1] = 1; hitexp[2] = 1;
    for (int k = 0; k < 4; k++) begin
      arm(32'h1000, 32'h40);
      idle_write(probe[k]);
      run_wait(1, 0, 3, -1, 0, -1, c, pw, rs);
      check("R5 R4 boundary cycles", c, hitexp[k] ? 0 : 6);
      check("R5 R4 boundary reason", rs, hitexp[k] ? 1 : 2);
    end
    // R5: trigger consumed
    run_wait(1, 0, 3, -1, 0, -1, c, pw, rs);
    check("R5 consumed cycles", c, 6);
    // R4: size zero matches nothing
    arm(32'h1000, 32'h0);
    idle_write(32'h1000);
    run_wait(1, 0, 3, 2, 32'h1000, -1, c, pw, rs);
    check("R4 size0 cycles", c, 6);
    // R6: re-arm clears trigger
    arm(32'h2000, 32'h10);
    idle_write(32'h2008);
    arm(32'h2000, 32'h10);
    run_wait(1, 0, 3, -1, 0, -1, c, pw, rs);
    check("R6 rearm cycles", c, 6);
    check("R6 rearm reason", rs, 2);
    // R4: write during sleep, deep and light
    run_wait(1, 1, 50, 5, 32'h200F, -1, c, pw, rs);
    check("R4 sleep hit deep cycles", c, 5 + 16);
    check("R4 sleep hit reason", rs, 1);
    run_wait(1, 0, 50, 5, 32'h2003, -1, c, pw, rs);
    check("R4 sleep hit light cycles", c, 5 + 2);
    // R4: write priority over deadline in the same cycle (wake edge at count 4)
    run_wait(1, 0, 3, 4, 32'h2000, -1, c, pw, rs);
    check("R4 priority cycles", c, 6);
    check("R4 priority reason", rs, 1);
    // R4: out-of-window write during sleep ignored
    run_wait(1, 0, 10, 3, 32'h2010, -1, c, pw, rs);
    check("R4 miss cycles", c, 11 + 2);
    check("R4 miss reason", rs, 2);
    // R7: timeout-only ignores writes and keeps a pending trigger
    idle_write(32'h2004);
    run_wait(0, 0, 6, 2, 32'h2004, -1, c, pw, rs);
    check("R7 timeout-only cycles", c, 7 + 2);
    check("R7 timeout-only reason", rs, 2);
    run_wait(1, 0, 6, -1, 0, -1, c, pw, rs);
    check("R7 trigger kept cycles", c, 0);
    check("R10 instant reason", rs, 1);
    // R11: wait command while stalled ignored
    run_wait(0, 0, 12, -1, 0, 3, c, pw, rs);
    check("R11 reissue cycles", c, 13 + 2);
    check("R11 reissue reason", rs, 2);
    check("R8 after stall pwr", pwr_state, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule